// File: doc/BRIEF.md
# Serial Two's Complement Negator

This block negates a binary word one bit per clock without an adder. Operand bits arrive least significant bit first, each qualified by a valid strobe. Bits up to and including the first 1 pass through unchanged, and every bit after it is inverted. A one-bit state flag remembers whether a 1 has already appeared in the current word. The flag and the current input together form a Mealy output. That output is visible at once on a serial pin, and it is also clocked into a collecting shift register on the same edge that updates the flag.

The shift register shifts toward bit 0 and enters each new bit at the most significant position. After WIDTH valid bits, the parallel output holds the negated word in normal bit order, and a done flag pulses for one cycle. An optional start-of-word pulse, sampled with the first bit of a word, forces that bit to use the cleared state and restarts the bit count. Words can therefore follow one another with no idle cycle, or a partial word can be abandoned.

Top module: `serial_negator`

## Requirements
- R1: A bit is consumed only on a rising clock edge where `bit_valid` is 1. On any edge with `bit_valid` at 0, `neg_out`, the state flag and the bit count keep their values, whatever `bit_in` and `word_start` carry.
- R2: While no 1 has been seen in the current word, an input 0 gives `serial_out` = 0 and the flag stays cleared.
- R3: While no 1 has been seen, an input 1 gives `serial_out` = 1 and sets the flag for the rest of the word.
- R4: Once the flag is set, `serial_out` is the inverse of `bit_in` for every further bit of the word.
- R5: A valid bit with `word_start` = 1 is treated as bit 0 of a new word. It uses the cleared state regardless of the previous flag, and it restarts the count.
- R6: On the edge that consumes the WIDTH-th valid bit of a word, `neg_out` takes the value (2^WIDTH − word) mod 2^WIDTH. The first bit received lands in bit 0. `neg_done` is 1 for exactly the one cycle that follows that edge. Between words, `neg_out` holds the last WIDTH Mealy output bits, with the newest bit at the MSB.
- R7: After a word completes, the flag and the count return to their start values, so the next word is negated correctly without a `word_start` pulse.
- R8: A synchronous active-low `rst_n` clears the flag, the count, `neg_out` and `neg_done` on the next edge.
- R9: An all-zero word negates to all zeros. The most negative word (MSB 1, all other bits 0) negates to itself, and no overflow indication exists.
- R10: With WIDTH = 6, the word 001010 (sent as 0,1,0,1,0,0) yields `neg_out` = 110110.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Data clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_in | input | 1 | Serial operand bit, LSB first |
| bit_valid | input | 1 | Qualifies `bit_in` on this edge |
| word_start | input | 1 | Marks the current valid bit as bit 0 of a word |
| serial_out | output | 1 | Mealy output bit for the current input (combinational) |
| neg_out | output | WIDTH | Collected negated word |
| neg_done | output | 1 | One-cycle pulse after the last bit of a word |

## Verification
`serial_out` depends combinationally on the current input and flag, so the bench drives inputs at the falling edge and checks that output 1 ns later, before the rising edge. `neg_out` and `neg_done` change one rising edge after the bit that causes them. The bench steps its reference model at that edge and compares both outputs 1 ns after it, on every cycle, whether or not that cycle is valid. The reference model is a queue of expected output bits plus an integer accumulation of the word received so far. When a word completes, the register image is also checked against the arithmetic negation.

// File: rtl/twos_neg_pkg.sv
// Shared types for the serial negator.
// Assumes nothing beyond IEEE 1800-2017 packages.
package twos_neg_pkg;

    // Flag encoding: cleared means no 1 seen yet in the word.
    typedef enum logic {
        SEEN_NONE = 1'b0,
        SEEN_ONE  = 1'b1
    } seen_t;

    // Mealy output: pass the bit through before the first 1, invert after it.
    function automatic logic mealy_bit(input seen_t st, input logic b);
        return (st == SEEN_ONE) ? ~b : b;
    endfunction

    // Next flag value given the state in effect for this bit.
    function automatic seen_t mealy_next(input seen_t st, input logic b);
        return (st == SEEN_ONE || b) ? SEEN_ONE : SEEN_NONE;
    endfunction

endpackage

// File: rtl/neg_flag_fsm.sv
// Two-state flag machine for serial negation.
// Produces the Mealy output bit and holds the "a 1 was seen" flag.
// Assumes word_end is asserted only together with bit_valid.
module neg_flag_fsm
    import twos_neg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  bit_valid,
    input  logic  bit_in,
    input  logic  word_start,
    input  logic  word_end,
    output logic  serial_out,
    output seen_t seen_q
);
    seen_t seen_eff;
    seen_t seen_nxt;

    // State in effect for this bit: a start pulse overrides the leftover flag.
    always_comb begin
        seen_eff   = word_start ? SEEN_NONE : seen_q;
        serial_out = mealy_bit(seen_eff, bit_in);
        seen_nxt   = word_end ? SEEN_NONE : mealy_next(seen_eff, bit_in);
    end

    // Flag register: advances only on valid bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= SEEN_NONE;
        end else if (bit_valid) begin
            seen_q <= seen_nxt;
        end
    end
endmodule

// File: rtl/neg_word_framer.sv
// Counts valid bits within a word and flags the last one.
// Assumes WIDTH >= 2. word_start restarts the count at the current bit.
module neg_word_framer #(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic word_start,
    output logic word_end,
    output logic done_q
);
    localparam int CW = $clog2(WIDTH);
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] idx;

    // Position of the current bit inside its word.
    always_comb begin
        idx      = word_start ? '0 : cnt_q;
        word_end = bit_valid && (idx == LAST);
    end

    // Bit counter and one-cycle completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= word_end;
            if (bit_valid) begin
                cnt_q <= word_end ? '0 : idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/neg_collect_sreg.sv
// Collecting shift register: new bit enters at the MSB and older bits move
// toward bit 0, so after WIDTH shifts the first bit sits at bit 0.
module neg_collect_sreg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             in_bit,
    output logic [WIDTH-1:0] par_q
);
    // Shift one place toward the LSB on each enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_q <= '0;
        end else if (shift_en) begin
            par_q <= {in_bit, par_q[WIDTH-1:1]};
        end
    end
endmodule

// File: rtl/serial_negator.sv
// Serial two's complement negator, LSB first, one bit per valid clock.
// Assumes WIDTH >= 2. The negation of the most negative value wraps to itself.
module serial_negator
    import twos_neg_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    input  logic             bit_valid,
    input  logic             word_start,
    output logic             serial_out,
    output logic [WIDTH-1:0] neg_out,
    output logic             neg_done
);
    logic  word_end;
    seen_t seen_q;

    neg_word_framer #(.WIDTH(WIDTH)) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_valid  (bit_valid),
        .word_start (word_start),
        .word_end   (word_end),
        .done_q     (neg_done)
    );

    neg_flag_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_valid  (bit_valid),
        .bit_in     (bit_in),
        .word_start (word_start),
        .word_end   (word_end),
        .serial_out (serial_out),
        .seen_q     (seen_q)
    );

    neg_collect_sreg #(.WIDTH(WIDTH)) u_sreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (bit_valid),
        .in_bit   (serial_out),
        .par_q    (neg_out)
    );
endmodule

// File: rtl/serial_negator_checker.sv
// Property checker for serial_negator, attached by bind.
// Observes ports and the state flag; drives nothing.
module serial_negator_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_in,
    input logic             bit_valid,
    input logic             word_start,
    input logic             serial_out,
    input logic [WIDTH-1:0] neg_out,
    input logic             neg_done,
    input logic             seen_q
);
    // R1: idle cycles leave the register and flag untouched.
    a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |=> ($stable(neg_out) && $stable(seen_q)));

    // R2: cleared state passes a 0 through.
    a_r2_zero_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && !bit_in && (word_start || !seen_q)) |-> !serial_out);

    // R3: cleared state passes a 1 through.
    a_r3_first_one: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && bit_in && (word_start || !seen_q)) |-> serial_out);

    // R4: set flag inverts the input.
    a_r4_invert: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && !word_start && seen_q) |-> (serial_out == !bit_in));

    // R6: completion is a single-cycle pulse caused by a valid bit.
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        neg_done |=> !neg_done);
    a_r6_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
        neg_done |-> $past(bit_valid));

    // R8: reset clears outputs and flag on the next edge.
    a_r8_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!neg_done && (neg_out == '0) && !seen_q));
endmodule

bind serial_negator serial_negator_checker #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_in     (bit_in),
    .bit_valid  (bit_valid),
    .word_start (word_start),
    .serial_out (serial_out),
    .neg_out    (neg_out),
    .neg_done   (neg_done),
    .seen_q     (seen_q)
);

// File: tb/serial_negator_test.sv
`timescale 1ns/100ps
// Bench for serial_negator: behavioural reference compared on every clock.
module serial_negator_test;
    localparam int W = 6;
    localparam longint MASK = (64'd1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bit_in = 1'b0;
    logic         bit_valid = 1'b0;
    logic         word_start = 1'b0;
    logic         serial_out;
    logic [W-1:0] neg_out;
    logic         neg_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Reference model state
    logic   exp_q[$];
    int     m_idx = 0;
    longint m_acc = 0;
    logic   m_done = 1'b0;

    always #2.5 clk = ~clk;

    serial_negator #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_valid(bit_valid),
        .word_start(word_start), .serial_out(serial_out),
        .neg_out(neg_out), .neg_done(neg_done)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic longint q_word();
        longint v = 0;
        for (int j = 0; j < W; j++) v |= longint'(exp_q[exp_q.size() - W + j]) << j;
        return v;
    endfunction

    task automatic model_clear();
        exp_q.delete();
        for (int j = 0; j < W; j++) exp_q.push_back(1'b0);
        m_idx = 0; m_acc = 0; m_done = 1'b0;
    endtask

    // Compare registered outputs against the model (called 1 ns after an edge).
    task automatic compare_regs();
        check("R1 neg_out image", longint'(neg_out), q_word());
        check("R6 done pulse", longint'(neg_done), longint'(m_done));
    endtask

    // One clock: drive at negedge, check Mealy output, step model at posedge.
    task automatic step(input logic v, input logic b, input logic s, input string wtag);
        int     i;
        longint acc;
        logic   eb;
        string  t;
        @(negedge clk);
        bit_valid = v; bit_in = b; word_start = s;
        #1;
        if (v) begin
            i   = s ? 0 : m_idx;
            acc = s ? 0 : m_acc;
            if (s) t = "R5 start bit";
            else if ((acc & ((64'd1 << i) - 1)) != 0) t = "R4 invert";
            else if (b) t = "R3 first one";
            else t = "R2 zero pass";
            acc |= longint'(b) << i;
            eb = logic'(((-acc) >> i) & 1);
            check(t, longint'(serial_out), longint'(eb));
        end
        @(posedge clk);
        #1;
        if (v) begin
            exp_q.push_back(eb);
            void'(exp_q.pop_front());
            m_done = (i == W - 1);
            if (m_done) begin
                check(wtag, longint'(neg_out), (-acc) & MASK);
                m_idx = 0; m_acc = 0;
            end else begin
                m_idx = i + 1; m_acc = acc;
            end
        end else begin
            m_done = 1'b0;
        end
        compare_regs();
    endtask

    task automatic send_word(input longint val, input bit use_start, input bit gaps,
                             input string wtag);
        for (int k = 0; k < W; k++) begin
            if (gaps && k == 2) step(1'b0, 1'($urandom), 1'($urandom), wtag);
            step(1'b1, logic'((val >> k) & 1), (k == 0) && use_start, wtag);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bit_valid = 1'b0; word_start = 1'b0;
        @(posedge clk); @(posedge clk);
        #1;
        model_clear();
        check("R8 reset neg_out", longint'(neg_out), 0);
        check("R8 reset done", longint'(neg_done), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        model_clear();
        do_reset();
        send_word(64'b001010, 1, 0, "R10 example word");
        send_word(0, 0, 0, "R9 zero word / R7 no start");
        send_word(64'b100000, 1, 0, "R9 most negative");
        send_word(64'b111111, 0, 0, "R7 back-to-back word");
        for (int n = 0; n < 3; n++) step(1'b0, 1'b1, 1'b1, "R1 idle");
        send_word(64'b010110, 1, 1, "R1 word with gap");
        // Abandon a partial word with a start pulse.
        step(1'b1, 1'b1, 1'b1, "R5 partial");
        step(1'b1, 1'b0, 1'b0, "R5 partial");
        send_word(64'b000100, 1, 0, "R5 restart word");
        // Reset in the middle of a word, then a word with no start pulse.
        step(1'b1, 1'b1, 1'b1, "R8 partial");
        do_reset();
        send_word(64'b101100, 0, 0, "R8 word after reset");
        for (int n = 0; n < 10; n++)
            send_word(longint'($urandom) & MASK, n[0], n[1], "R6 random word");
        step(1'b0, 1'b0, 1'b0, "R6 tail");
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule